// File: doc/BRIEF.md
# Configuration Status Word Error Capture

This block holds the upper byte of a bus device's configuration Status register together with the fixed capability bits beside it. The device's bus engine reports error and abort events as single-cycle pulses. The block records each one in a sticky bit. Some of these bits are gated by enable bits from the Command register, and each bit is gated its own way. Software reads the 16-bit status word and clears recorded events by writing ones. A write takes effect only in the bytes whose byte enable is asserted.

The block also holds the parity checker used while the device is master on a memory read. In the cycle of a read data phase it folds AD[31:0] and C/BE[3:0] into one bit. In the next cycle it combines that bit with PAR. If the XOR of all 37 bits is 1, it flags a data parity error. During memory writes, the PERR pulse returned by the target is the data parity error event instead. The sticky bits are cleared only by the hard reset. The soft reset and the stop control do not touch them.

Top module: `stsreg_top`

## Requirements
- R1: The sticky bits at positions 15, 14, 13, 12 and 8 are write-one-to-clear. A write clears a bit only when `wr_en` is 1, the bit's byte enable (`wr_be[1]` for bits 15:8) is 1 and the written bit is 1. Writing 0, or writing with that byte enable at 0, leaves the bit unchanged.
- R2: An active-low `hard_rst_n` clears all sticky bits. `soft_rst` and `ctl_stop` have no effect on any status bit.
- R3: Bit 15 (any data parity error) is set in the cycle after a data parity error event, whatever the value of `cmd_perr_resp`.
- R4: Bit 14 is set in the cycle after `addr_perr` only when `cmd_serr_en` and `cmd_perr_resp` are both 1 in that cycle.
- R5: Bit 13 is set in the cycle after `mst_abort`. Bit 12 is set in the cycle after `tgt_abort`.
- R6: Bit 11 reads 0, bits 10:9 read 01, bit 7 reads 1 and bits 6:0 read 0, whatever is written. After reset the word reads 16'h0280.
- R7: Bit 8 is set in the cycle after a data parity error event only when `cmd_perr_resp` is 1 in the cycle of the event.
- R8: For a read data phase marked by `rd_dphase` in cycle N, the event is raised in cycle N+1. It is raised when the XOR of `ad` and `cbe` from cycle N with `par` from cycle N+1 is 1. The status bits change in cycle N+2.
- R9: When a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R10: A `wr_tgt_perr` pulse during a master write data phase counts as a data parity error event for bits 15 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset, ignored by the status bits |
| ctl_stop | input | 1 | Stop control, ignored by the status bits |
| cmd_serr_en | input | 1 | Command register system-error enable |
| cmd_perr_resp | input | 1 | Command register parity-error response enable |
| addr_perr | input | 1 | Address parity error pulse |
| rd_dphase | input | 1 | Master memory-read data phase, AD and C/BE valid |
| ad | input | 32 | Address/data lines |
| cbe | input | 4 | Command/byte-enable lines |
| par | input | 1 | Parity line, one clock after its data |
| wr_tgt_perr | input | 1 | Target PERR seen in a master write data phase |
| mst_abort | input | 1 | Own master cycle ended by master abort |
| tgt_abort | input | 1 | Own master cycle ended by target abort |
| wr_en | input | 1 | Configuration write strobe for this word |
| wr_be | input | 2 | Write byte enables |
| wr_data | input | 16 | Write data |
| stat_rd | output | 16 | Status word read value |

## Verification
The assertions take for granted that every event input is held low while `hard_rst_n` is active. They also assume that `par` always belongs to the data phase of the cycle before it, so a read data phase never lacks its parity cycle. The stimulus drives all inputs to zero during reset. It pairs each `rd_dphase` with a `par` value in the following cycle, and otherwise lets events, enables and clearing writes vary freely, including collisions between events and writes.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  localparam int STAT_W   = 16;
  localparam int N_STICKY = 5;

  localparam int POS_DPE  = 15;
  localparam int POS_SSE  = 14;
  localparam int POS_RMA  = 13;
  localparam int POS_RTA  = 12;
  localparam int POS_STA  = 11;
  localparam int POS_DEVL = 9;
  localparam int POS_MDPE = 8;
  localparam int POS_FBB  = 7;

  localparam logic [1:0] DEVSEL_MEDIUM = 2'b01;

  typedef enum logic [2:0] {
    SK_DPE  = 3'd0,
    SK_SSE  = 3'd1,
    SK_RMA  = 3'd2,
    SK_RTA  = 3'd3,
    SK_MDPE = 3'd4
  } sticky_e;

  function automatic int sticky_pos(input int k);
    case (k)
      0: return POS_DPE;
      1: return POS_SSE;
      2: return POS_RMA;
      3: return POS_RTA;
      default: return POS_MDPE;
    endcase
  endfunction

  function automatic logic parity_fail(input logic folded, input logic par_bit);
    return folded ^ par_bit;
  endfunction
endpackage

// File: rtl/stsreg_parchk.sv
module stsreg_parchk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_dphase,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  input  logic             par,
  output logic             rd_par_err
);
  import stsreg_pkg::*;

  logic pend_q;
  logic fold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fold_q <= 1'b0;
    end else begin
      pend_q <= rd_dphase;
      fold_q <= rd_dphase & (^{ad, cbe});
    end
  end

  assign rd_par_err = pend_q & parity_fail(fold_q, par);
endmodule

// File: rtl/stsreg_gate.sv
module stsreg_gate
  import stsreg_pkg::*;
(
  input  logic                addr_perr,
  input  logic                rd_par_err,
  input  logic                wr_tgt_perr,
  input  logic                mst_abort,
  input  logic                tgt_abort,
  input  logic                serr_en,
  input  logic                perr_resp,
  output logic                dpe_evt,
  output logic [N_STICKY-1:0] set_vec
);
  always_comb begin
    dpe_evt = rd_par_err | wr_tgt_perr;
    set_vec = '0;
    set_vec[SK_DPE]  = dpe_evt;
    set_vec[SK_SSE]  = addr_perr & serr_en & perr_resp;
    set_vec[SK_RMA]  = mst_abort;
    set_vec[SK_RTA]  = tgt_abort;
    set_vec[SK_MDPE] = dpe_evt & perr_resp;
  end
endmodule

// File: rtl/stsreg_sticky.sv
module stsreg_sticky
  import stsreg_pkg::*;
#(
  parameter int N = N_STICKY
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        set_vec,
  input  logic                wr_en,
  input  logic [STAT_W/8-1:0] wr_be,
  input  logic [STAT_W-1:0]   wr_data,
  output logic [N-1:0]        q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int POS = sticky_pos(k);
    logic clr;
    assign clr = wr_en & wr_be[POS/8] & wr_data[POS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[k] <= 1'b0;
      else if (set_vec[k]) q[k] <= 1'b1;
      else if (clr)        q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/stsreg_top.sv
module stsreg_top
  import stsreg_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              ctl_stop,
  input  logic              cmd_serr_en,
  input  logic              cmd_perr_resp,
  input  logic              addr_perr,
  input  logic              rd_dphase,
  input  logic [AD_W-1:0]   ad,
  input  logic [CBE_W-1:0]  cbe,
  input  logic              par,
  input  logic              wr_tgt_perr,
  input  logic              mst_abort,
  input  logic              tgt_abort,
  input  logic              wr_en,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  output logic [15:0]       stat_rd
);
  logic                rd_par_err;
  logic                dpe_evt;
  logic [N_STICKY-1:0] set_vec;
  logic [N_STICKY-1:0] sticky_q;
  logic                unused_resets;

  assign unused_resets = soft_rst ^ ctl_stop;

  stsreg_parchk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
    .clk(clk), .rst_n(hard_rst_n), .rd_dphase(rd_dphase),
    .ad(ad), .cbe(cbe), .par(par), .rd_par_err(rd_par_err)
  );

  stsreg_gate u_gate (
    .addr_perr(addr_perr), .rd_par_err(rd_par_err), .wr_tgt_perr(wr_tgt_perr),
    .mst_abort(mst_abort), .tgt_abort(tgt_abort), .serr_en(cmd_serr_en),
    .perr_resp(cmd_perr_resp), .dpe_evt(dpe_evt), .set_vec(set_vec)
  );

  stsreg_sticky #(.N(N_STICKY)) u_stk (
    .clk(clk), .rst_n(hard_rst_n), .set_vec(set_vec), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .q(sticky_q)
  );

  always_comb begin
    stat_rd = '0;
    stat_rd[POS_DPE]                = sticky_q[SK_DPE];
    stat_rd[POS_SSE]                = sticky_q[SK_SSE];
    stat_rd[POS_RMA]                = sticky_q[SK_RMA];
    stat_rd[POS_RTA]                = sticky_q[SK_RTA];
    stat_rd[POS_STA]                = 1'b0;
    stat_rd[POS_DEVL+1:POS_DEVL]    = DEVSEL_MEDIUM;
    stat_rd[POS_MDPE]               = sticky_q[SK_MDPE];
    stat_rd[POS_FBB]                = 1'b1;
  end
endmodule

// File: rtl/stsreg_chk.sv
module stsreg_chk (
  input logic        clk,
  input logic        hard_rst_n,
  input logic        cmd_serr_en,
  input logic        cmd_perr_resp,
  input logic        addr_perr,
  input logic        rd_dphase,
  input logic        mst_abort,
  input logic        tgt_abort,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic        rd_par_err,
  input logic        dpe_evt,
  input logic [15:0] stat_rd
);
  AST_DPE_SET: assert property (@(posedge clk) disable iff (!hard_rst_n)
    dpe_evt |=> stat_rd[15]); // R3
  AST_SSE_GATED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(stat_rd[14]) |-> $past(addr_perr && cmd_serr_en && cmd_perr_resp)); // R4
  AST_MDPE_GATED: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(stat_rd[8]) |-> $past(dpe_evt && cmd_perr_resp)); // R7
  AST_RMA_SET_WINS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    mst_abort |=> stat_rd[13]); // R9
  AST_RTA_SET: assert property (@(posedge clk) disable iff (!hard_rst_n)
    tgt_abort |=> stat_rd[12]); // R5
  AST_RTA_HOLD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (stat_rd[12] && !(wr_en && wr_be[1] && wr_data[12])) |=> stat_rd[12]); // R1
  AST_PAR_AFTER_PHASE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    rd_par_err |-> $past(rd_dphase)); // R8
endmodule

bind stsreg_top stsreg_chk u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .cmd_serr_en(cmd_serr_en),
  .cmd_perr_resp(cmd_perr_resp), .addr_perr(addr_perr), .rd_dphase(rd_dphase),
  .mst_abort(mst_abort), .tgt_abort(tgt_abort), .wr_en(wr_en), .wr_be(wr_be),
  .wr_data(wr_data), .rd_par_err(rd_par_err), .dpe_evt(dpe_evt), .stat_rd(stat_rd)
);

// File: tb/stsreg_top_test.sv
`timescale 1ns/1ps
module stsreg_top_test;
  logic clk = 1'b0;
  logic hard_rst_n = 1'b1;
  logic soft_rst, ctl_stop, cmd_serr_en, cmd_perr_resp, addr_perr, rd_dphase;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic par, wr_tgt_perr, mst_abort, tgt_abort, wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] stat_rd;

  int n_tests = 0;
  int n_fail  = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stsreg_top uut (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst), .ctl_stop(ctl_stop),
    .cmd_serr_en(cmd_serr_en), .cmd_perr_resp(cmd_perr_resp), .addr_perr(addr_perr),
    .rd_dphase(rd_dphase), .ad(ad), .cbe(cbe), .par(par), .wr_tgt_perr(wr_tgt_perr),
    .mst_abort(mst_abort), .tgt_abort(tgt_abort), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .stat_rd(stat_rd)
  );

  // Reference model: sticky flags by name, pending read phases in a queue.
  bit m_dpe, m_sse, m_rma, m_rta, m_mdpe;
  int phase_q[$];   // -1 = no phase, else count of ones in AD and C/BE

  function automatic logic [15:0] model_word();
    logic [15:0] w = 16'h0280;
    w[15] = m_dpe; w[14] = m_sse; w[13] = m_rma; w[12] = m_rta; w[8] = m_mdpe;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!hard_rst_n) begin
      {m_dpe, m_sse, m_rma, m_rta, m_mdpe} = '0;
      phase_q.delete();
    end else begin
      int ones = -1;
      bit perr_now, clr;
      if (phase_q.size() > 0) ones = phase_q.pop_front();
      perr_now = (ones >= 0 && ((ones + int'(par)) % 2) == 1) || wr_tgt_perr;
      clr = wr_en && wr_be[1];
      if (clr && wr_data[15]) m_dpe  = 0;
      if (clr && wr_data[14]) m_sse  = 0;
      if (clr && wr_data[13]) m_rma  = 0;
      if (clr && wr_data[12]) m_rta  = 0;
      if (clr && wr_data[8])  m_mdpe = 0;
      if (perr_now) m_dpe = 1;
      if (perr_now && cmd_perr_resp) m_mdpe = 1;
      if (addr_perr && cmd_serr_en && cmd_perr_resp) m_sse = 1;
      if (mst_abort) m_rma = 1;
      if (tgt_abort) m_rta = 1;
      phase_q.push_back(rd_dphase ? $countones({ad, cbe}) : -1);
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      n_tests++;
      if (stat_rd !== model_word()) begin
        n_fail++;
        $display("FAIL model compare (R1 R3 R4 R5 R7 R8 R9 R10) act=%h exp=%h", stat_rd, model_word());
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    soft_rst = 0; ctl_stop = 0; addr_perr = 0; rd_dphase = 0; ad = '0; cbe = '0;
    par = 0; wr_tgt_perr = 0; mst_abort = 0; tgt_abort = 0; wr_en = 0; wr_be = '0; wr_data = '0;
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic clear_all();
    idle(); wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; step(); idle();
  endtask

  initial begin
    idle(); cmd_serr_en = 0; cmd_perr_resp = 0;
    step(); hard_rst_n = 0; step(); step(); hard_rst_n = 1; step();
    chk("R6 reset value", stat_rd, 16'h0280);
    compare_on = 1;

    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF; step(); idle();
    chk("R6 fixed bits ignore write", stat_rd, 16'h0280);

    wr_tgt_perr = 1; step(); idle();
    chk("R10 R3 R7 target perr with response off", stat_rd, 16'h8280);

    wr_en = 1; wr_be = 2'b11; wr_data = 16'h0000; step(); idle();
    chk("R1 write zero keeps bit", stat_rd, 16'h8280);
    wr_en = 1; wr_be = 2'b01; wr_data = 16'hFFFF; step(); idle();
    chk("R1 masked byte keeps bit", stat_rd, 16'h8280);
    wr_en = 1; wr_be = 2'b10; wr_data = 16'h8000; step(); idle();
    chk("R1 write one clears", stat_rd, 16'h0280);

    cmd_serr_en = 1; cmd_perr_resp = 0; addr_perr = 1; step(); idle();
    chk("R4 serr gated by perr_resp", stat_rd, 16'h0280);
    cmd_serr_en = 0; cmd_perr_resp = 1; addr_perr = 1; step(); idle();
    chk("R4 serr gated by serr_en", stat_rd, 16'h0280);
    cmd_serr_en = 1; addr_perr = 1; step(); idle();
    chk("R4 serr set", stat_rd, 16'h4280);

    mst_abort = 1; step(); idle();
    chk("R5 master abort", stat_rd, 16'h6280);
    tgt_abort = 1; step(); idle();
    chk("R5 target abort", stat_rd, 16'h7280);

    soft_rst = 1; ctl_stop = 1; step(); idle(); step();
    chk("R2 soft reset and stop ignored", stat_rd, 16'h7280);

    mst_abort = 1; wr_en = 1; wr_be = 2'b10; wr_data = 16'h2000; step(); idle();
    chk("R9 set beats clear", stat_rd, 16'h7280);

    clear_all();
    chk("R1 clear all", stat_rd, 16'h0280);

    rd_dphase = 1; ad = 32'h0000_0001; cbe = 4'h0; step();
    idle(); par = 0; step(); idle();
    chk("R8 R7 read parity error", stat_rd, 16'h8380);

    clear_all();
    rd_dphase = 1; ad = 32'h0000_0003; cbe = 4'h1; step();
    idle(); par = 1; step(); idle();
    chk("R8 read parity good", stat_rd, 16'h0280);

    mst_abort = 1; step(); idle();
    hard_rst_n = 0; step(); hard_rst_n = 1; step();
    chk("R2 hard reset clears", stat_rd, 16'h0280);

    for (int i = 0; i < 3000; i++) begin
      bit pend_par = rd_dphase;
      idle();
      cmd_serr_en   = ($urandom % 4) != 0;
      cmd_perr_resp = ($urandom % 3) != 0;
      addr_perr     = ($urandom % 12) == 0;
      rd_dphase     = ($urandom % 3) == 0;
      ad            = $urandom;
      cbe           = 4'($urandom);
      par           = pend_par ? 1'($urandom) : 1'b0;
      wr_tgt_perr   = ($urandom % 15) == 0;
      mst_abort     = ($urandom % 14) == 0;
      tgt_abort     = ($urandom % 14) == 0;
      soft_rst      = ($urandom % 20) == 0;
      ctl_stop      = ($urandom % 20) == 0;
      wr_en         = ($urandom % 5) == 0;
      wr_be         = 2'($urandom);
      wr_data       = 16'($urandom);
      step();
    end
    idle(); step(); step();

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule